// File: doc/BRIEF.md
# TSO Store Buffer with Early Ownership Requests

This block holds the stores of one core between execution and the level-one data cache. Each store takes a slot in program order. Its address and its data arrive later and separately, each tagged with the slot index. The core marks slots non-speculative one at a time, also in program order. Only the oldest slot may leave, and it leaves only when four things are true: its address is known, its data is known, it has been marked retired, and its cache line is held with write permission. This keeps the total store order that a strongly ordered core needs.

Write permission is requested through a read-for-ownership channel. The buffer does not wait for a slot to become the oldest before it asks. Any slot whose address is known and whose line is neither owned nor already requested can raise a request, with the oldest such slot first. Several ownership misses can therefore be outstanding at the same time. A grant marks every buffered store on that line as owned. A snoop invalidation removes that ownership, and the buffer then asks again. Loads look up the buffer and take data from the youngest store to the same word. A fence holds back later loads until every store ahead of it has left. A flush drops every slot the core has not yet retired.

Top module: `tso_store_buffer`

## Requirements
- R1: Stores leave through the commit port strictly in allocation order. A younger store whose line is owned does not leave while the oldest store is still waiting.
- R2: The oldest store does not commit until both its address and its data have been written.
- R3: The oldest store does not commit until the core has marked it retired.
- R4: The oldest store does not commit until its line has been granted. `grant_line` and `rfo_line` carry address bits [31:6], since lines are 64 bytes.
- R5: A read-for-ownership request goes out for any buffered store whose address is known, even before that store is retired or oldest. The oldest eligible store is served first, and at most one request is outstanding per line.
- R6: While the oldest store is eligible, one store commits per clock cycle. Back-to-back commits drain consecutive stores on an owned line.
- R7: A load whose word address, bits [31:2], matches a buffered store receives the data of the youngest matching store. If that youngest match has no data yet, `fwd_wait` is raised instead of `fwd_hit`.
- R8: After a fence, `load_block` stays high from the next cycle until every store that was buffered before the fence has committed.
- R9: A flush removes all unretired stores. Retired stores stay and still commit.
- R10: With DEPTH stores buffered, `full` is high and a new allocation is ignored. The occupied slots are not disturbed.
- R11: A snoop invalidation of a line clears ownership for the stores on it. A new request for that line is then issued, and commit waits for a new grant.
- R12: After reset the buffer is empty. No commit, no ownership request and no load block are signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate a slot for the next store in program order |
| alloc_idx | output | 3 | Index of the slot the next allocation takes |
| full | output | 1 | All slots are occupied |
| empty | output | 1 | No slot is occupied |
| addr_wr_valid | input | 1 | Write the address of a slot |
| addr_wr_idx | input | 3 | Slot receiving the address |
| addr_wr_addr | input | 32 | Store byte address |
| data_wr_valid | input | 1 | Write the data of a slot |
| data_wr_idx | input | 3 | Slot receiving the data |
| data_wr_data | input | 32 | Store data |
| retire_valid | input | 1 | Mark the oldest unretired slot as retired |
| flush | input | 1 | Drop all unretired slots |
| rfo_valid | output | 1 | Ownership request this cycle |
| rfo_line | output | 26 | Line of the ownership request |
| grant_valid | input | 1 | Ownership granted for a line |
| grant_line | input | 26 | Granted line |
| snoop_valid | input | 1 | Line invalidated by another agent |
| snoop_line | input | 26 | Invalidated line |
| commit_valid | output | 1 | Oldest store is written to the cache this cycle |
| commit_addr | output | 32 | Address of the committing store |
| commit_data | output | 32 | Data of the committing store |
| load_valid | input | 1 | Load lookup request |
| load_addr | input | 32 | Load byte address |
| fwd_hit | output | 1 | Load data supplied by the buffer |
| fwd_wait | output | 1 | Youngest matching store has no data yet |
| fwd_data | output | 32 | Forwarded data |
| fence_valid | input | 1 | Fence issued this cycle |
| load_block | output | 1 | Loads held back by a pending fence |

## Verification
The hardest case to reach from the ports is a younger store that owns its line while the oldest store is still waiting for its grant. That needs two requests to different lines outstanding at once, with the grants returned in the reverse order. The bench sets this up by writing the addresses of three stores on consecutive cycles: two on one line and one on another, so that a shared-line request is also suppressed. It then grants the younger line first and checks that nothing commits until the older line is granted. A second hard case is losing a line between the grant and the commit. The bench keeps a store unretired while it is granted, invalidates the line, and only then retires the store.

// File: rtl/tso_sb_pkg.sv
package tso_sb_pkg;
  // Per-slot status bits; address and data live in separate arrays.
  typedef struct packed {
    logic addr_ok;
    logic data_ok;
    logic owned;
    logic pend;
  } sb_flags_t;
endpackage

// File: rtl/tso_sb_pick.sv
// Circular priority picker: first set request starting at base,
// walking upward (oldest-first) or downward (youngest-first).
module tso_sb_pick #(
  parameter int N       = 8,
  parameter int IW      = 3,
  parameter bit REVERSE = 1'b0
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] base,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      logic [IW-1:0] cand;
      cand = REVERSE ? (base - IW'(i)) : (base + IW'(i));
      if (!found && req[cand]) begin
        found = 1'b1;
        idx   = cand;
      end
    end
  end
endmodule

// File: rtl/tso_sb_match.sv
// Compares a key against every slot address above bit LSB.
module tso_sb_match #(
  parameter int N   = 8,
  parameter int AW  = 32,
  parameter int LSB = 6
) (
  input  logic [AW-1:0]     ent_addr [N],
  input  logic [N-1:0]      live,
  input  logic [AW-LSB-1:0] key,
  output logic [N-1:0]      hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = live[g] && (ent_addr[g][AW-1:LSB] == key);
  end
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer #(
  parameter int DEPTH      = 8,
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           alloc_valid,
  output logic [$clog2(DEPTH)-1:0]       alloc_idx,
  output logic                           full,
  output logic                           empty,
  input  logic                           addr_wr_valid,
  input  logic [$clog2(DEPTH)-1:0]       addr_wr_idx,
  input  logic [AW-1:0]                  addr_wr_addr,
  input  logic                           data_wr_valid,
  input  logic [$clog2(DEPTH)-1:0]       data_wr_idx,
  input  logic [DW-1:0]                  data_wr_data,
  input  logic                           retire_valid,
  input  logic                           flush,
  output logic                           rfo_valid,
  output logic [AW-$clog2(LINE_BYTES)-1:0] rfo_line,
  input  logic                           grant_valid,
  input  logic [AW-$clog2(LINE_BYTES)-1:0] grant_line,
  input  logic                           snoop_valid,
  input  logic [AW-$clog2(LINE_BYTES)-1:0] snoop_line,
  output logic                           commit_valid,
  output logic [AW-1:0]                  commit_addr,
  output logic [DW-1:0]                  commit_data,
  input  logic                           load_valid,
  input  logic [AW-1:0]                  load_addr,
  output logic                           fwd_hit,
  output logic                           fwd_wait,
  output logic [DW-1:0]                  fwd_data,
  input  logic                           fence_valid,
  output logic                           load_block
);
  import tso_sb_pkg::*;

  localparam int IW   = $clog2(DEPTH);
  localparam int CW   = IW + 1;
  localparam int OFFW = $clog2(LINE_BYTES);
  localparam int LW   = AW - OFFW;
  localparam int WLSB = 2;

  // ---------------- state ----------------
  logic [IW-1:0] head, head_n, tail, tail_n;
  logic [CW-1:0] count, count_n, rcnt, rcnt_n, fence_cnt, fence_cnt_n;
  sb_flags_t     flags_q [DEPTH];
  sb_flags_t     flags_n [DEPTH];
  logic [AW-1:0] addr_q  [DEPTH];
  logic [DW-1:0] data_q  [DEPTH];

  // ---------------- per-slot views ----------------
  logic [DEPTH-1:0] in_use, aok_v, dok_v, own_v, pend_v;
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [IW-1:0] rel;
    assign rel      = IW'(g) - head;
    assign in_use[g] = {1'b0, rel} < count;
    assign aok_v[g]  = flags_q[g].addr_ok;
    assign dok_v[g]  = flags_q[g].data_ok;
    assign own_v[g]  = flags_q[g].owned;
    assign pend_v[g] = flags_q[g].pend;
  end

  logic [DEPTH-1:0] known;
  assign known = in_use & aok_v;

  // ---------------- control strobes ----------------
  logic alloc_ok, ret_ok, addr_we, data_we;
  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign alloc_idx = tail;
  assign alloc_ok  = alloc_valid && !full && !flush;
  assign ret_ok    = retire_valid && (rcnt < count) && !flush;
  assign addr_we   = addr_wr_valid && in_use[addr_wr_idx] && !flush;
  assign data_we   = data_wr_valid && in_use[data_wr_idx] && !flush;

  // ---------------- commit (oldest only) ----------------
  assign commit_valid = (rcnt != '0) && flags_q[head].addr_ok &&
                        flags_q[head].data_ok && flags_q[head].owned;
  assign commit_addr  = addr_q[head];
  assign commit_data  = data_q[head];

  // ---------------- ownership request selection ----------------
  logic          rfo_found;
  logic [IW-1:0] rfo_idx;
  tso_sb_pick #(.N(DEPTH), .IW(IW), .REVERSE(1'b0)) u_rfo_pick (
    .req(known & ~own_v & ~pend_v), .base(head),
    .found(rfo_found), .idx(rfo_idx)
  );
  assign rfo_valid = rfo_found;
  assign rfo_line  = addr_q[rfo_idx][AW-1:OFFW];

  // ---------------- line comparators ----------------
  logic [DEPTH-1:0] rfo_m, grant_m, snoop_m, inh_m, ld_m;
  logic [DEPTH-1:0] wr_sel;
  for (genvar g = 0; g < DEPTH; g++) begin : g_wrsel
    assign wr_sel[g] = (addr_wr_idx == IW'(g));
  end

  tso_sb_match #(.N(DEPTH), .AW(AW), .LSB(OFFW)) u_m_rfo (
    .ent_addr(addr_q), .live(known), .key(rfo_line), .hit(rfo_m));
  tso_sb_match #(.N(DEPTH), .AW(AW), .LSB(OFFW)) u_m_grant (
    .ent_addr(addr_q), .live(known), .key(grant_line), .hit(grant_m));
  tso_sb_match #(.N(DEPTH), .AW(AW), .LSB(OFFW)) u_m_snoop (
    .ent_addr(addr_q), .live(known), .key(snoop_line), .hit(snoop_m));
  tso_sb_match #(.N(DEPTH), .AW(AW), .LSB(OFFW)) u_m_inh (
    .ent_addr(addr_q), .live(known & ~wr_sel),
    .key(addr_wr_addr[AW-1:OFFW]), .hit(inh_m));
  tso_sb_match #(.N(DEPTH), .AW(AW), .LSB(WLSB)) u_m_load (
    .ent_addr(addr_q), .live(known), .key(load_addr[AW-1:WLSB]), .hit(ld_m));

  logic unused_ld_bits;
  assign unused_ld_bits = ^load_addr[WLSB-1:0];

  // State a newly written address picks up from its line.
  logic [LW-1:0] wr_line;
  logic inh_own, inh_pend, wr_grant, wr_snoop;
  assign wr_line  = addr_wr_addr[AW-1:OFFW];
  assign inh_own  = |(inh_m & own_v);
  assign inh_pend = |(inh_m & pend_v) || (rfo_valid && (wr_line == rfo_line));
  assign wr_grant = grant_valid && (wr_line == grant_line);
  assign wr_snoop = snoop_valid && (wr_line == snoop_line);

  // ---------------- store-to-load forwarding ----------------
  logic          ld_found;
  logic [IW-1:0] ld_idx;
  tso_sb_pick #(.N(DEPTH), .IW(IW), .REVERSE(1'b1)) u_ld_pick (
    .req(ld_m), .base(tail - IW'(1)), .found(ld_found), .idx(ld_idx)
  );
  assign fwd_hit    = load_valid && ld_found && flags_q[ld_idx].data_ok;
  assign fwd_wait   = load_valid && ld_found && !flags_q[ld_idx].data_ok;
  assign fwd_data   = data_q[ld_idx];
  assign load_block = (fence_cnt != '0);

  // ---------------- slot flag next state ----------------
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      flags_n[i] = flags_q[i];
      if (alloc_ok && (tail == IW'(i))) flags_n[i] = '0;
      if (rfo_valid && rfo_m[i]) flags_n[i].pend = 1'b1;
      if (grant_valid && grant_m[i]) begin
        flags_n[i].owned = 1'b1;
        flags_n[i].pend  = 1'b0;
      end
      if (snoop_valid && snoop_m[i]) flags_n[i].owned = 1'b0;
      if (addr_we && wr_sel[i]) begin
        flags_n[i].addr_ok = 1'b1;
        flags_n[i].owned   = (inh_own || wr_grant) && !wr_snoop;
        flags_n[i].pend    = inh_pend && !wr_grant;
      end
      if (data_we && (data_wr_idx == IW'(i))) flags_n[i].data_ok = 1'b1;
    end
  end

  // ---------------- pointer next state ----------------
  logic [CW-1:0] cmt, fbase;
  assign cmt = CW'(commit_valid);

  always_comb begin
    head_n = head + IW'(commit_valid);
    if (flush) begin
      tail_n  = head + rcnt[IW-1:0];
      count_n = rcnt - cmt;
      rcnt_n  = rcnt - cmt;
    end else begin
      tail_n  = tail + IW'(alloc_ok);
      count_n = count + CW'(alloc_ok) - cmt;
      rcnt_n  = rcnt + CW'(ret_ok) - cmt;
    end
    if (fence_valid)            fbase = count - cmt;
    else if (fence_cnt != '0)   fbase = fence_cnt - cmt;
    else                        fbase = '0;
    fence_cnt_n = (flush && (fbase > rcnt_n)) ? rcnt_n : fbase;
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head      <= '0;
      tail      <= '0;
      count     <= '0;
      rcnt      <= '0;
      fence_cnt <= '0;
      for (int i = 0; i < DEPTH; i++) flags_q[i] <= '0;
    end else begin
      head      <= head_n;
      tail      <= tail_n;
      count     <= count_n;
      rcnt      <= rcnt_n;
      fence_cnt <= fence_cnt_n;
      for (int i = 0; i < DEPTH; i++) flags_q[i] <= flags_n[i];
    end
  end

  // Datapath arrays: written under enable, no reset.
  always_ff @(posedge clk) begin
    if (addr_we) addr_q[addr_wr_idx] <= addr_wr_addr;
    if (data_we) data_q[data_wr_idx] <= data_wr_data;
  end

endmodule

// File: rtl/tso_sb_chk.sv
module tso_sb_chk #(
  parameter int DEPTH      = 8,
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [$clog2(DEPTH):0]           count,
  input logic [$clog2(DEPTH):0]           rcnt,
  input logic [$clog2(DEPTH)-1:0]         head,
  input logic                             commit_valid,
  input logic                             flush,
  input logic                             fence_valid,
  input logic                             empty,
  input logic                             load_block,
  input logic                             rfo_valid,
  input logic [AW-$clog2(LINE_BYTES)-1:0] rfo_line,
  input logic                             grant_valid
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = IW + 1;

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r9_flush_keeps_retired: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == ($past(rcnt) - CW'($past(commit_valid))));

  a_r6_commit_advances_head: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> head == ($past(head) + IW'(1)));

  a_r8_fence_blocks_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_valid && !empty && !commit_valid && !flush) |=> load_block);

  a_r5_one_request_per_line: assert property (@(posedge clk) disable iff (!rst_n)
    (rfo_valid && !grant_valid) |=> !(rfo_valid && rfo_line == $past(rfo_line)));
endmodule

bind tso_store_buffer tso_sb_chk #(
  .DEPTH(DEPTH), .AW(AW), .LINE_BYTES(LINE_BYTES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .count(count), .rcnt(rcnt), .head(head),
  .commit_valid(commit_valid), .flush(flush), .fence_valid(fence_valid),
  .empty(empty), .load_block(load_block), .rfo_valid(rfo_valid),
  .rfo_line(rfo_line), .grant_valid(grant_valid)
);

// File: tb/tso_store_buffer_tb_top.sv
`timescale 1ns/1ps
module tso_store_buffer_tb_top;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 0, addr_wr_valid = 0, data_wr_valid = 0;
  logic [2:0]  alloc_idx, addr_wr_idx = 0, data_wr_idx = 0;
  logic        full, empty;
  logic [31:0] addr_wr_addr = 0, data_wr_data = 0;
  logic        retire_valid = 0, flush = 0;
  logic        rfo_valid;
  logic [25:0] rfo_line, grant_line = 0, snoop_line = 0;
  logic        grant_valid = 0, snoop_valid = 0;
  logic        commit_valid;
  logic [31:0] commit_addr, commit_data;
  logic        load_valid = 0;
  logic [31:0] load_addr = 0;
  logic        fwd_hit, fwd_wait;
  logic [31:0] fwd_data;
  logic        fence_valid = 0, load_block;

  always #4 clk = ~clk;

  tso_store_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
    .full(full), .empty(empty), .addr_wr_valid(addr_wr_valid),
    .addr_wr_idx(addr_wr_idx), .addr_wr_addr(addr_wr_addr),
    .data_wr_valid(data_wr_valid), .data_wr_idx(data_wr_idx),
    .data_wr_data(data_wr_data), .retire_valid(retire_valid), .flush(flush),
    .rfo_valid(rfo_valid), .rfo_line(rfo_line), .grant_valid(grant_valid),
    .grant_line(grant_line), .snoop_valid(snoop_valid), .snoop_line(snoop_line),
    .commit_valid(commit_valid), .commit_addr(commit_addr),
    .commit_data(commit_data), .load_valid(load_valid), .load_addr(load_addr),
    .fwd_hit(fwd_hit), .fwd_wait(fwd_wait), .fwd_data(fwd_data),
    .fence_valid(fence_valid), .load_block(load_block)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Advance one edge; pulse inputs drop right after it.
  task automatic step();
    @(posedge clk);
    #1;
    alloc_valid = 0; addr_wr_valid = 0; data_wr_valid = 0; retire_valid = 0;
    flush = 0; fence_valid = 0; grant_valid = 0; snoop_valid = 0;
  endtask

  task automatic push(input logic [31:0] a, input logic [31:0] d,
                      input bit ret, output logic [2:0] idx);
    alloc_valid = 1;
    #1 idx = alloc_idx;
    step();
    addr_wr_valid = 1; addr_wr_idx = idx; addr_wr_addr = a;
    data_wr_valid = 1; data_wr_idx = idx; data_wr_data = d;
    retire_valid = ret;
    step();
  endtask

  task automatic grant(input logic [31:0] a);
    grant_valid = 1; grant_line = a[31:6];
    step();
  endtask

  // Stimulus/expected table: {store address, store data}
  localparam logic [63:0] VEC [6] = '{
    {32'h0000_1000, 32'hA5A5_0001},
    {32'h0000_2044, 32'h1234_5678},
    {32'h8000_00FC, 32'hFFFF_0000},
    {32'h0001_0040, 32'h0BAD_CAFE},
    {32'hFFFF_FFC0, 32'h0000_0000},
    {32'h1357_9BD8, 32'hDEAD_BEEF}
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] i0, i1, i2, ix;
    logic [31:0] a;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R12 reset state
    check("R12 empty", empty, 1);
    check("R12 full", full, 0);
    check("R12 commit", commit_valid, 0);
    check("R12 rfo", rfo_valid, 0);
    check("R12 load_block", load_block, 0);

    // Table walk: R5 request, R4 gate, R1 commit content, R6 pop
    for (int v = 0; v < 6; v++) begin
      a = VEC[v][63:32];
      push(a, VEC[v][31:0], 1, ix);
      #1;
      check("R5 rfo issued", rfo_valid, 1);
      check("R5 rfo line", rfo_line, a[31:6]);
      check("R4 no commit before grant", commit_valid, 0);
      step();
      grant(a);
      #1;
      check("R4 commit after grant", commit_valid, 1);
      check("R1 commit addr", commit_addr, a);
      check("R1 commit data", commit_data, VEC[v][31:0]);
      step();
      #1 check("R6 drained", empty, 1);
    end

    // R2: address only, retired and granted -> waits for data
    alloc_valid = 1; #1 ix = alloc_idx; step();
    addr_wr_valid = 1; addr_wr_idx = ix; addr_wr_addr = 32'h0000_3000;
    retire_valid = 1; step();
    grant(32'h0000_3000);
    #1 check("R2 no commit without data", commit_valid, 0);
    data_wr_valid = 1; data_wr_idx = ix; data_wr_data = 32'h22; step();
    #1 check("R2 commit once data written", commit_valid, 1);
    step();

    // R3: written and owned but not retired
    push(32'h0000_3100, 32'h33, 0, ix);
    step();
    grant(32'h0000_3100);
    #1 check("R3 no commit before retire", commit_valid, 0);
    retire_valid = 1; step();
    #1 check("R3 commit after retire", commit_valid, 1);
    step();

    // R5/R1/R6: parallel requests, shared line, out-of-order grants
    alloc_valid = 1; #1 i0 = alloc_idx; step();
    alloc_valid = 1; #1 i1 = alloc_idx; step();
    alloc_valid = 1; #1 i2 = alloc_idx; step();
    addr_wr_valid = 1; addr_wr_idx = i0; addr_wr_addr = 32'h0000_4000;
    data_wr_valid = 1; data_wr_idx = i0; data_wr_data = 32'h40; step();
    #1 check("R5 first request line X", rfo_line, 26'h100);
    addr_wr_valid = 1; addr_wr_idx = i1; addr_wr_addr = 32'h0000_5000;
    data_wr_valid = 1; data_wr_idx = i1; data_wr_data = 32'h50; step();
    #1 check("R5 second request line Y in parallel", rfo_line, 26'h140);
    addr_wr_valid = 1; addr_wr_idx = i2; addr_wr_addr = 32'h0000_4008;
    data_wr_valid = 1; data_wr_idx = i2; data_wr_data = 32'h48; step();
    #1 check("R5 no duplicate request for line X", rfo_valid, 0);
    retire_valid = 1; step();
    retire_valid = 1; step();
    retire_valid = 1; step();
    grant(32'h0000_5000);
    #1 check("R1 younger owned store waits", commit_valid, 0);
    grant(32'h0000_4000);
    #1 check("R6 commit 1 addr", commit_addr, 32'h0000_4000);
    check("R6 commit 1 valid", commit_valid, 1);
    step();
    #1 check("R6 commit 2 addr", commit_addr, 32'h0000_5000);
    check("R6 commit 2 valid", commit_valid, 1);
    step();
    #1 check("R6 commit 3 addr", commit_addr, 32'h0000_4008);
    check("R6 commit 3 valid", commit_valid, 1);
    step();
    #1 check("R6 all drained", empty, 1);

    // R7 forwarding, then R9 flush
    push(32'h0000_6010, 32'h1111_1111, 0, ix);
    push(32'h0000_6010, 32'h2222_2222, 0, ix);
    load_valid = 1; load_addr = 32'h0000_6012;
    #1 check("R7 youngest hit", fwd_hit, 1);
    check("R7 youngest data", fwd_data, 32'h2222_2222);
    load_addr = 32'h0000_6014;
    #1 check("R7 other word misses", fwd_hit, 0);
    alloc_valid = 1; #1 ix = alloc_idx; step();
    addr_wr_valid = 1; addr_wr_idx = ix; addr_wr_addr = 32'h0000_6010; step();
    load_addr = 32'h0000_6010;
    #1 check("R7 wait on missing data", fwd_wait, 1);
    check("R7 no hit while waiting", fwd_hit, 0);
    retire_valid = 1; step();
    flush = 1; step();
    #1 check("R9 retired store kept", fwd_hit, 1);
    check("R9 older data visible after flush", fwd_data, 32'h1111_1111);
    check("R9 not empty", empty, 0);
    load_valid = 0;
    grant(32'h0000_6010);
    #1 check("R9 retired store commits", commit_data, 32'h1111_1111);
    step();
    #1 check("R9 drained", empty, 1);

    // R8 fence
    push(32'h0000_7000, 32'h70, 1, ix);
    push(32'h0000_7400, 32'h74, 1, ix);
    fence_valid = 1; step();
    #1 check("R8 load blocked", load_block, 1);
    grant(32'h0000_7000);
    #1 check("R8 first commit", commit_valid, 1);
    step();
    #1 check("R8 still blocked", load_block, 1);
    grant(32'h0000_7400);
    step();
    #1 check("R8 released after drain", load_block, 0);
    check("R8 empty", empty, 1);

    // R10 full
    push(32'h0000_8000, 32'h8888, 0, ix);
    step();
    grant(32'h0000_8000);
    for (int k = 0; k < DEPTH - 1; k++) begin
      alloc_valid = 1; step();
    end
    #1 check("R10 full", full, 1);
    alloc_valid = 1; step();
    #1 check("R10 still full", full, 1);
    retire_valid = 1; step();
    #1 check("R10 head intact commit", commit_valid, 1);
    check("R10 head intact data", commit_data, 32'h8888);
    step();
    flush = 1; step();
    #1 check("R10 emptied by flush", empty, 1);
    check("R10 not full", full, 0);

    // R11 snoop invalidation
    push(32'h0000_9000, 32'h99, 0, ix);
    step();
    grant(32'h0000_9000);
    snoop_valid = 1; snoop_line = 26'h240; step();
    #1 check("R11 re-request", rfo_valid, 1);
    check("R11 re-request line", rfo_line, 26'h240);
    step();
    retire_valid = 1; step();
    #1 check("R11 no commit after loss", commit_valid, 0);
    grant(32'h0000_9000);
    #1 check("R11 commit after regrant", commit_valid, 1);
    step();
    #1 check("R11 drained", empty, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule